// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is a synchronous static memory of 36-bit words. It captures every command on the rising clock edge and runs the matching data phase two enabled cycles later, for reads and for writes alike. Because both kinds of operation have the same delay, a bus master can issue reads and writes in any order on consecutive cycles, with no idle cycle when the data bus changes direction. The pad-level bidirectional data bus is split into a data-in word, a data-out word and a drive-enable flag, so the block can sit behind a pad ring or be used as an on-chip pipelined memory.

A load command carries an external address and a read or write type. Each following cycle with the advance flag high continues the same operation at the next address of a four-word burst, in either linear or interleaved order. Three chip enables gate new loads, and a deselected load only empties the pipeline. Operations already in flight still complete. An active-low clock enable freezes the whole pipeline, including the memory write port. An asynchronous output enable can switch the data driver off at any moment. Four active-low byte selects mask the four 9-bit lanes of each written word.

Top module: `zbt_sram`

## Requirements
- R1: A read loaded or continued at enabled edge k puts the addressed word on `dq_out` and raises `dq_drive` just after enabled edge k+2, provided `oe_n` is low.
- R2: For a write loaded or continued at enabled edge k, `dq_in` and `bw_n` are sampled at enabled edge k+2, and the memory is updated at that edge.
- R3: Reads and writes may be issued in any mix on consecutive cycles. A read issued one cycle after a write to the same word returns the newly written data.
- R4: While `cke_n` is high, no input except `oe_n` is sampled, the memory is not written, and `dq_out` and `dq_drive` hold their values. Counting resumes when `cke_n` goes low again.
- R5: The chip counts as selected when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A load (`adv_ld`=0) while the chip is not selected starts no operation and ends any burst, and its data phase leaves `dq_drive` low. Operations loaded earlier still finish. A later `adv_ld`=1 then starts nothing.
- R6: With `lbo`=0 captured at the load, the burst address low two bits are (start + n) mod 4 for n = 0,1,2,3. The upper address bits stay fixed, the sequence wraps after four words, and every advance repeats the loaded read or write type.
- R7: With `lbo`=1 captured at the load, the burst address low two bits are start XOR n.
- R8: Lane i is bits [9i+8:9i] of the word. A write updates lane i only when `bw_n[i]`=0, and other lanes keep their old contents.
- R9: `dq_drive` is low after the data-phase edge of a write or of a deselected or empty slot.
- R10: `oe_n`=1 forces `dq_drive` low at once, with no clock edge. `dq_out` is unaffected, and `dq_drive` returns as soon as `oe_n` goes low while a read phase is active.
- R11: After reset `dq_drive` is low and the pipeline is empty. An advance with no burst loaded starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| cke_n | input | 1 | Clock enable, active low; high freezes the pipeline |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| we_n | input | 1 | Operation type at load: 0 write, 1 read |
| lbo | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address for a load |
| bw_n | input | 4 | Active-low byte-lane write selects, sampled in the write data phase |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 36 | Write data, sampled in the write data phase |
| dq_out | output | 36 | Read data register |
| dq_drive | output | 1 | High when the data bus should be driven |

## Verification
The assertions assume that reset is applied first and that `cke_n` is never X after reset. They also assume that every advance follows a load while the chip is selected or a deselect, which holds because each stimulus cycle is a complete, defined command. The stimulus fills every address first so that reads never return unwritten words. It then mixes directed sequences with random cycles in which load, advance, deselect, frozen clock, burst order, byte selects and output enable are chosen freely. Read and write types are mixed freely, since any order is legal for this block.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // Low two address bits of burst beat n from a start value.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction

  // Replace the lanes whose active-low select is 0.
  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [LANES-1:0]  sel_n);
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++)
      if (!sel_n[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    return r;
  endfunction
endpackage

// File: rtl/zbt_cmd.sv
module zbt_cmd
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              sel,
  input  logic              adv_ld,
  input  logic              wr_in,
  input  logic              ilv_in,
  input  logic [ADDR_W-1:0] addr,
  output logic              s1_vld,
  output logic              s1_wr,
  output logic [ADDR_W-1:0] s1_addr
);
  logic              act, wr_q, ilv_q;
  logic [ADDR_W-1:0] base;
  logic [1:0]        beat;
  logic [1:0]        beat_nx;

  assign beat_nx = beat + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; wr_q <= 1'b0; ilv_q <= 1'b0; base <= '0; beat <= '0;
      s1_vld <= 1'b0; s1_wr <= 1'b0; s1_addr <= '0;
    end else if (cke) begin
      if (!adv_ld) begin
        if (sel) begin
          act <= 1'b1; base <= addr; beat <= 2'd0; wr_q <= wr_in; ilv_q <= ilv_in;
          s1_vld <= 1'b1; s1_wr <= wr_in; s1_addr <= addr;
        end else begin
          act <= 1'b0; s1_vld <= 1'b0;
        end
      end else if (act) begin
        beat    <= beat_nx;
        s1_vld  <= 1'b1;
        s1_wr   <= wr_q;
        s1_addr <= {base[ADDR_W-1:2], burst_low(base[1:0], beat_nx, ilv_q)};
      end else begin
        s1_vld <= 1'b0;
      end
    end
  end

  // R5: a deselected load empties the first stage
  a_r5_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !adv_ld && !sel) |=> !s1_vld);

  // R6: advancing keeps the upper address bits of the burst
  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && adv_ld && act) |=> (s1_vld && s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));
endmodule

// File: rtl/zbt_stage.sv
module zbt_stage #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              in_vld,
  input  logic              in_wr,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_vld,
  output logic              out_wr,
  output logic [ADDR_W-1:0] out_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0; out_wr <= 1'b0; out_addr <= '0;
    end else if (cke) begin
      out_vld <= in_vld; out_wr <= in_wr; out_addr <= in_addr;
    end
  end

  // R4: a frozen clock holds the second stage
  a_r4_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ($stable(out_vld) && $stable(out_wr) && $stable(out_addr)));
endmodule

// File: rtl/zbt_array.sv
module zbt_array
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              ph_vld,
  input  logic              ph_wr,
  input  logic [ADDR_W-1:0] ph_addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  wsel_n,
  output logic [WORD_W-1:0] rdata,
  output logic              drv_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              wr_ev, rd_ev;

  assign wr_ev = cke && ph_vld && ph_wr;
  assign rd_ev = cke && ph_vld && !ph_wr;

  always_ff @(posedge clk) begin
    if (wr_ev) mem[ph_addr] <= lane_merge(mem[ph_addr], wdata, wsel_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0; drv_q <= 1'b0;
    end else if (cke) begin
      drv_q <= rd_ev;
      if (rd_ev) rdata <= mem[ph_addr];
    end
  end

  // R4: a frozen clock holds the read outputs
  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ($stable(rdata) && $stable(drv_q)));
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adv_ld,
  input  logic              we_n,
  input  logic              lbo,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bw_n,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] dq_in,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_drive
);
  logic              cke, sel;
  logic              s1_vld, s1_wr, s2_vld, s2_wr, drv_q;
  logic [ADDR_W-1:0] s1_addr, s2_addr;

  assign cke = !cke_n;
  assign sel = !ce1_n && ce2 && !ce3_n;

  zbt_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cke(cke), .sel(sel), .adv_ld(adv_ld),
    .wr_in(!we_n), .ilv_in(lbo), .addr(addr),
    .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr));

  zbt_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .cke(cke),
    .in_vld(s1_vld), .in_wr(s1_wr), .in_addr(s1_addr),
    .out_vld(s2_vld), .out_wr(s2_wr), .out_addr(s2_addr));

  zbt_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .cke(cke),
    .ph_vld(s2_vld), .ph_wr(s2_wr), .ph_addr(s2_addr),
    .wdata(dq_in), .wsel_n(bw_n), .rdata(dq_out), .drv_q(drv_q));

  assign dq_drive = drv_q && !oe_n;

  // R1: a read in the second stage drives the bus after the next enabled edge
  a_r1_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && s2_vld && !s2_wr) |=> drv_q);

  // R9: a write or empty slot in the second stage releases the bus
  a_r9_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !(s2_vld && !s2_wr)) |=> !drv_q);
endmodule

// File: tb/sim_zbt_sram.sv
`timescale 1ns/1ps
module sim_zbt_sram;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke_n = 1'b0, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic adv_ld = 1'b0, we_n = 1'b1, lbo = 1'b0, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0]  bw_n = 4'hF;
  logic [35:0] dq_in = '0;
  logic [35:0] dq_out;
  logic        dq_drive;

  int n_chk = 0, n_bad = 0;
  bit rand_bw = 1'b0;

  always #5 clk = ~clk;

  zbt_sram #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adv_ld(adv_ld), .we_n(we_n), .lbo(lbo), .addr(addr), .bw_n(bw_n), .oe_n(oe_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive));

  // reference state
  logic [35:0] mm [DEPTH];
  bit m_act, m_wr, m_ilv;
  logic [AW-1:0] m_base;
  int m_beat;
  bit p1v, p1w, p2v, p2w;
  logic [AW-1:0] p1a, p2a;
  bit e_drv;
  logic [35:0] e_dat;

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, int n, bit ilv);
    int lo;
    lo = ilv ? (int'(b[1:0]) ^ n) : ((int'(b[1:0]) + n) % 4);
    return {b[AW-1:2], 2'(lo)};
  endfunction

  task automatic model_edge();
    bit sel;
    if (cke_n) return;
    if (p2v) begin
      if (p2w) begin
        for (int l = 0; l < 4; l++)
          if (!bw_n[l]) mm[p2a][l*9 +: 9] = dq_in[l*9 +: 9];
        e_drv = 0;
      end else begin
        e_dat = mm[p2a]; e_drv = 1;
      end
    end else e_drv = 0;
    p2v = p1v; p2w = p1w; p2a = p1a;
    sel = (ce1_n == 0) && (ce2 == 1) && (ce3_n == 0);
    if (!adv_ld) begin
      if (sel) begin
        m_act = 1; m_base = addr; m_beat = 0; m_wr = !we_n; m_ilv = lbo;
        p1v = 1; p1w = !we_n; p1a = addr;
      end else begin
        m_act = 0; p1v = 0;
      end
    end else if (m_act) begin
      m_beat = (m_beat + 1) % 4;
      p1v = 1; p1w = m_wr; p1a = beat_addr(m_base, m_beat, m_ilv);
    end else p1v = 0;
  endtask

  task automatic check(input string tag);
    bit xd;
    xd = e_drv && !oe_n;
    n_chk++;
    if (dq_drive !== xd) begin
      n_bad++;
      $display("FAIL %s dq_drive actual %b expected %b at %0t", tag, dq_drive, xd, $time);
    end else if (e_drv && dq_out !== e_dat) begin
      n_bad++;
      $display("FAIL %s dq_out actual %h expected %h at %0t", tag, dq_out, e_dat, $time);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, check at next negedge
  task automatic step(input string tag, input logic ckn, c1n, c2, c3n, adv, wen, lb,
                      input logic [AW-1:0] a);
    cke_n = ckn; ce1_n = c1n; ce2 = c2; ce3_n = c3n; adv_ld = adv; we_n = wen; lbo = lb;
    addr = a;
    dq_in = {$urandom(), $urandom()} & 36'hF_FFFF_FFFF;
    bw_n = rand_bw ? 4'($urandom()) : 4'h0;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic ld_rd(input string t, input logic [AW-1:0] a, input logic lb = 0);
    step(t, 0, 0, 1, 0, 0, 1, lb, a);
  endtask
  task automatic ld_wr(input string t, input logic [AW-1:0] a, input logic lb = 0);
    step(t, 0, 0, 1, 0, 0, 0, lb, a);
  endtask
  task automatic adv_c(input string t);
    step(t, 0, 0, 1, 0, 1, 1, 0, '0);
  endtask
  task automatic desel(input string t);
    step(t, 0, 1, 1, 0, 0, 1, 0, '0);
  endtask
  task automatic frz(input string t);
    step(t, 1, 0, 1, 0, 0, 0, 0, 6'h3F);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    m_act = 0; p1v = 0; p2v = 0; e_drv = 0; e_dat = '0; m_beat = 0;
    repeat (3) @(negedge clk);
    check("R11");                       // R11: reset state, bus released
    rst_n = 1'b1;
    repeat (3) adv_c("R11");            // R11: advance with nothing loaded

    for (int a = 0; a < DEPTH; a++) ld_wr("R2", 6'(a));  // R2: fill memory
    desel("R2"); desel("R2");
    for (int a = 0; a < 8; a++) ld_rd("R2", 6'(a));
    desel("R1"); desel("R1"); desel("R1");

    ld_rd("R1", 6'd5); desel("R1"); desel("R1"); desel("R1");

    // R3: alternating reads and writes, read just after write
    ld_wr("R3", 6'd7); ld_rd("R3", 6'd7); ld_wr("R3", 6'd8); ld_rd("R3", 6'd8);
    ld_rd("R3", 6'd7); ld_wr("R3", 6'd7); ld_rd("R3", 6'd7);
    desel("R3"); desel("R3"); desel("R3");

    // R8: byte-lane masks
    rand_bw = 1;
    for (int i = 0; i < 6; i++) begin ld_wr("R8", 6'd9); ld_rd("R8", 6'd9); end
    rand_bw = 0;
    desel("R8"); desel("R8"); desel("R8");

    // R4: freeze with reads in flight
    ld_rd("R4", 6'd5); ld_rd("R4", 6'd6); frz("R4"); frz("R4"); frz("R4");
    ld_wr("R4", 6'd6); frz("R4"); ld_rd("R4", 6'd6); frz("R4");
    desel("R4"); frz("R4"); desel("R4"); desel("R4");

    // R5: deselect by each enable while reads complete, then advance
    ld_rd("R5", 6'd1); step("R5", 0, 1, 1, 0, 0, 1, 0, 6'd2);
    ld_rd("R5", 6'd3); step("R5", 0, 0, 0, 0, 0, 1, 0, 6'd4);
    ld_rd("R5", 6'd5); step("R5", 0, 0, 1, 1, 0, 0, 0, 6'd6);
    adv_c("R5"); adv_c("R5"); adv_c("R5");

    // R6: linear bursts with wrap, read and write
    ld_rd("R6", 6'h0E); repeat (5) adv_c("R6");
    ld_wr("R6", 6'h13); repeat (3) adv_c("R6");
    ld_rd("R6", 6'h13); repeat (4) adv_c("R6");
    desel("R6"); desel("R6"); desel("R6");

    // R7: interleaved bursts
    ld_rd("R7", 6'h0D, 1); repeat (4) adv_c("R7");
    ld_wr("R7", 6'h2A, 1); repeat (3) adv_c("R7");
    ld_rd("R7", 6'h29, 1); repeat (3) adv_c("R7");
    desel("R7"); desel("R7"); desel("R7");

    // R9: read followed by write and deselect releases the bus
    ld_rd("R9", 6'd3); ld_wr("R9", 6'd4); desel("R9"); ld_rd("R9", 6'd4);
    desel("R9"); desel("R9"); desel("R9");

    // R10: asynchronous output enable
    ld_rd("R10", 6'd3); desel("R10"); desel("R10");
    #1 oe_n = 1'b1; #1 check("R10");
    #1 oe_n = 1'b0; #1 check("R10");
    @(negedge clk); desel("R10");

    // R3: random mixed traffic
    rand_bw = 1;
    for (int i = 0; i < 4000; i++) begin
      logic ckn, c1n, c2, c3n, adv;
      ckn = ($urandom() % 8) == 0;
      c1n = ($urandom() % 10) == 0;
      c2  = ($urandom() % 10) != 0;
      c3n = ($urandom() % 10) == 0;
      adv = ($urandom() % 2) == 0;
      oe_n = ($urandom() % 8) == 0;
      step("R3", ckn, c1n, c2, c3n, adv, 1'($urandom()), 1'($urandom()), 6'($urandom()));
    end
    oe_n = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule